// File: doc/BRIEF.md
# Framebuffer Rectangle Fill and Copy Engine

This block runs rectangle operations on a linear, byte-addressed framebuffer. A fill paints a rectangle with one colour; a copy moves a rectangle of pixels from one screen position to another and stays correct when the source and destination overlap. A pixel is one to four bytes wide, the byte count being derived from the colour depth. A screen line holds exactly one screen width of pixels, with no padding.

Each finished operation records its destination rectangle in a circular redraw ring. A display agent later asks for a flush. If the screen is not marked invalidated, the ring replays its rectangles oldest first, one per cycle. If the screen is marked invalidated, the ring drops everything it holds, because a full repaint follows anyway.

The memory side is byte-wide. A read strobe returns data on `memRData` in the next cycle. A copy costs one read and one write per byte. A fill costs one write per byte.

Top module: `rect_engine`

## Requirements
- R1: A pixel is B = ceil(depth/8) bytes, for depth 1 to 32. Byte k of pixel (x, y) lives at address B*(x + scrWidth*y) + k.
- R2: A fill writes colour byte (k mod B) to byte k of each line of the rectangle, counting from the least significant colour byte. It covers every one of the h lines and issues no memory reads.
- R3: After a copy, every destination byte holds the value its source byte had before the copy started, including when the two rectangles overlap.
- R4: A copy whose destination row is below its source row (reqY > reqSrcY) handles lines from the last one upward. Any other copy handles lines from the first one downward. The first write therefore lands in line reqY+h-1 or line reqY.
- R5: Within a line, a copy whose destination column is right of its source column (reqX > reqSrcX) moves bytes from the highest address to the lowest. Every other operation moves bytes from the lowest address upward.
- R6: An operation with h = 0 or w = 0 makes no memory access, still raises done, and still records its rectangle in the ring.
- R7: A request is taken only while busy is low. done is high for exactly one cycle, after the last write. A request raised while busy has no effect on memory or on the ring.
- R8: Each operation records {reqX, reqY, reqW, reqH} in the ring: the destination position for a copy. A flush with invalidated low emits the held rectangles in push order, one per cycle on qValid, until the ring is empty.
- R9: A flush with invalidated high empties the ring without raising qValid.
- R10: The ring holds 512 rectangles. A push into a full ring overwrites the oldest entry and sets overflow, which stays set until reset.
- R11: During reset and right after it, busy, done, qValid, overflow, memRe and memWe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation request |
| reqCopy | input | 1 | 1 = copy, 0 = fill |
| reqColour | input | 32 | Fill colour, least significant byte first |
| reqSrcX | input | COORD_W | Copy source column |
| reqSrcY | input | COORD_W | Copy source row |
| reqX | input | COORD_W | Destination column |
| reqY | input | COORD_W | Destination row |
| reqW | input | COORD_W | Width in pixels |
| reqH | input | COORD_W | Height in lines |
| pixDepth | input | 6 | Colour depth in bits, 1 to 32 |
| scrWidth | input | COORD_W | Screen width in pixels |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| memRe | output | 1 | Byte read strobe |
| memWe | output | 1 | Byte write strobe |
| memAddr | output | 2*COORD_W+3 | Byte address |
| memWData | output | 8 | Write data |
| memRData | input | 8 | Read data, valid the cycle after memRe |
| flushReq | input | 1 | Flush request pulse |
| invalidated | input | 1 | Whole screen invalid: discard on flush |
| qValid | output | 1 | Ring entry presented |
| qX | output | COORD_W | Entry column |
| qY | output | COORD_W | Entry row |
| qW | output | COORD_W | Entry width |
| qH | output | COORD_W | Entry height |
| overflow | output | 1 | Sticky ring overflow |

## Verification
The assertions take three things for granted. Read data arrives exactly one cycle after a read strobe. A flush is never requested while an operation is running or while a previous flush is still draining. Every rectangle lies inside the screen, so row and address arithmetic never wraps. The stimulus meets these conditions: it uses a 16-pixel-wide screen whose rectangles stay within a 1 KiB byte memory, it waits for done before starting the next step, and it allows each drain to finish before another flush. The overlapping copies use every depth class and cover each vertical and horizontal direction.

// File: rtl/rect_pkg.sv
package rect_pkg;
  typedef struct packed {
    logic load;
    logic rdEn;
    logic wrEn;
    logic step;
    logic push;
  } rectStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_PUSH  = 2'd3
  } rectState_e;
endpackage

// File: rtl/rect_ctrl.sv
module rect_ctrl
  import rect_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqCopy,
  input  logic        reqZero,
  input  logic        lastByte,
  input  logic        lastLine,
  output rectStrobe_t strb,
  output logic        busy,
  output logic        done
);
  rectState_e state, stateNext;
  logic opCopy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opCopy <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.load) opCopy <= reqCopy;
    end
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strb.load = 1'b1;
        if (reqZero)      stateNext = ST_PUSH;
        else if (reqCopy) stateNext = ST_READ;
        else              stateNext = ST_WRITE;
      end
      ST_READ: begin
        strb.rdEn = 1'b1;
        stateNext = ST_WRITE;
      end
      ST_WRITE: begin
        strb.wrEn = 1'b1;
        strb.step = 1'b1;
        if (lastByte && lastLine) stateNext = ST_PUSH;
        else if (opCopy)          stateNext = ST_READ;
        else                      stateNext = ST_WRITE;
      end
      ST_PUSH: begin
        strb.push = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_PUSH);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> strb.wrEn); // R3
  AST_ZERO_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && reqZero) |=> (!strb.rdEn && !strb.wrEn && done)); // R6
endmodule

// File: rtl/rect_dp.sv
module rect_dp
  import rect_pkg::*;
#(
  parameter int COORD_W = 12,
  localparam int ADDR_W = 2 * COORD_W + 3,
  localparam int BPL_W  = COORD_W + 3
)(
  input  logic               clk,
  input  logic               rstN,
  input  rectStrobe_t        strb,
  input  logic               reqCopy,
  input  logic [31:0]        reqColour,
  input  logic [COORD_W-1:0] reqSrcX,
  input  logic [COORD_W-1:0] reqSrcY,
  input  logic [COORD_W-1:0] reqX,
  input  logic [COORD_W-1:0] reqY,
  input  logic [COORD_W-1:0] reqW,
  input  logic [COORD_W-1:0] reqH,
  input  logic [5:0]         pixDepth,
  input  logic [COORD_W-1:0] scrWidth,
  input  logic [7:0]         memRData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [7:0]         memWData,
  output logic               lastByte,
  output logic               lastLine,
  output logic [4*COORD_W-1:0] pushRect
);
  logic               opCopy;
  logic [31:0]        colour;
  logic [COORD_W-1:0] sx, sy, dx, dy, rw, rh, scrW;
  logic [2:0]         bypp;
  logic [BPL_W-1:0]   bi;
  logic [COORD_W-1:0] li;
  logic [1:0]         cIdx;

  logic [BPL_W-1:0]   bpl, pos;
  logic [COORD_W-1:0] lineOff;
  logic               vUp, hDown;
  logic [ADDR_W-1:0]  srcPix, dstPix, srcAddr, dstAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opCopy <= 1'b0; colour <= '0;
      sx <= '0; sy <= '0; dx <= '0; dy <= '0; rw <= '0; rh <= '0; scrW <= '0;
      bypp <= '0; bi <= '0; li <= '0; cIdx <= '0;
    end else if (strb.load) begin
      opCopy <= reqCopy;
      colour <= reqColour;
      sx <= reqSrcX; sy <= reqSrcY; dx <= reqX; dy <= reqY;
      rw <= reqW; rh <= reqH; scrW <= scrWidth;
      bypp <= 3'((pixDepth + 6'd7) >> 3);
      bi <= '0; li <= '0; cIdx <= '0;
    end else if (strb.step) begin
      if (lastByte) begin
        bi   <= '0;
        li   <= li + 1'b1;
        cIdx <= '0;
      end else begin
        bi   <= bi + 1'b1;
        cIdx <= ({1'b0, cIdx} == bypp - 3'd1) ? 2'd0 : cIdx + 2'd1;
      end
    end
  end

  assign bpl      = BPL_W'(bypp) * BPL_W'(rw);
  assign lastByte = (bi == bpl - BPL_W'(1));
  assign lastLine = (li == rh - COORD_W'(1));
  assign vUp      = opCopy && (dy > sy);
  assign hDown    = opCopy && (dx > sx);
  assign lineOff  = vUp ? (rh - COORD_W'(1) - li) : li;
  assign pos      = hDown ? (bpl - BPL_W'(1) - bi) : bi;

  assign srcPix  = ADDR_W'(sx) + ADDR_W'(scrW) * (ADDR_W'(sy) + ADDR_W'(lineOff));
  assign dstPix  = ADDR_W'(dx) + ADDR_W'(scrW) * (ADDR_W'(dy) + ADDR_W'(lineOff));
  assign srcAddr = ADDR_W'(bypp) * srcPix + ADDR_W'(pos);
  assign dstAddr = ADDR_W'(bypp) * dstPix + ADDR_W'(pos);

  assign memAddr  = strb.rdEn ? srcAddr : dstAddr;
  assign memWData = opCopy ? memRData : colour[{cIdx, 3'b000} +: 8];
  assign pushRect = {dx, dy, rw, rh};

  AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |-> opCopy); // R2
  AST_STEP_IN_RECT: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (li < rh)); // R2
endmodule

// File: rtl/rect_ring.sv
module rect_ring #(
  parameter int ENTRY_W   = 48,
  parameter int DEPTH_LOG = 9,
  localparam int DEPTH    = 1 << DEPTH_LOG
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               push,
  input  logic [ENTRY_W-1:0] pushData,
  input  logic               flushReq,
  input  logic               invalidated,
  output logic               qValid,
  output logic [ENTRY_W-1:0] qData,
  output logic               overflow
);
  logic [ENTRY_W-1:0]   store [DEPTH];
  logic [DEPTH_LOG-1:0] wrPtr, rdPtr;
  logic [DEPTH_LOG:0]   count;
  logic                 draining, pop, full, drop;

  assign full = (count == (DEPTH_LOG+1)'(DEPTH));
  assign pop  = draining && (count != '0);
  assign drop = push && full && !pop;

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
    if (pop)  qData <= store[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; count <= '0;
      draining <= 1'b0; qValid <= 1'b0; overflow <= 1'b0;
    end else begin
      wrPtr  <= wrPtr + DEPTH_LOG'(push);
      qValid <= pop && !(flushReq && invalidated);
      if (drop) overflow <= 1'b1;
      if (flushReq && invalidated) begin
        rdPtr    <= wrPtr;
        count    <= push ? (DEPTH_LOG+1)'(1) : '0;
        draining <= 1'b0;
      end else begin
        rdPtr <= rdPtr + DEPTH_LOG'(pop || drop);
        if (!drop) count <= count + (DEPTH_LOG+1)'(push) - (DEPTH_LOG+1)'(pop);
        if (flushReq)                    draining <= 1'b1;
        else if (draining && count == '0) draining <= 1'b0;
      end
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= (DEPTH_LOG+1)'(DEPTH)); // R10
  AST_INVALID_DISCARD: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && invalidated && !push) |=> (count == '0 && !qValid)); // R9
endmodule

// File: rtl/rect_engine.sv
module rect_engine
  import rect_pkg::*;
#(
  parameter int COORD_W   = 12,
  parameter int RING_LOG  = 9,
  localparam int ADDR_W   = 2 * COORD_W + 3
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqCopy,
  input  logic [31:0]        reqColour,
  input  logic [COORD_W-1:0] reqSrcX,
  input  logic [COORD_W-1:0] reqSrcY,
  input  logic [COORD_W-1:0] reqX,
  input  logic [COORD_W-1:0] reqY,
  input  logic [COORD_W-1:0] reqW,
  input  logic [COORD_W-1:0] reqH,
  input  logic [5:0]         pixDepth,
  input  logic [COORD_W-1:0] scrWidth,
  output logic               busy,
  output logic               done,
  output logic               memRe,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [7:0]         memWData,
  input  logic [7:0]         memRData,
  input  logic               flushReq,
  input  logic               invalidated,
  output logic               qValid,
  output logic [COORD_W-1:0] qX,
  output logic [COORD_W-1:0] qY,
  output logic [COORD_W-1:0] qW,
  output logic [COORD_W-1:0] qH,
  output logic               overflow
);
  rectStrobe_t         strb;
  logic                lastByte, lastLine, reqZero;
  logic [4*COORD_W-1:0] pushRect, qData;

  assign reqZero = (reqW == '0) || (reqH == '0);

  rect_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCopy(reqCopy),
    .reqZero(reqZero), .lastByte(lastByte), .lastLine(lastLine),
    .strb(strb), .busy(busy), .done(done)
  );

  rect_dp #(.COORD_W(COORD_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqCopy(reqCopy), .reqColour(reqColour),
    .reqSrcX(reqSrcX), .reqSrcY(reqSrcY), .reqX(reqX), .reqY(reqY),
    .reqW(reqW), .reqH(reqH), .pixDepth(pixDepth), .scrWidth(scrWidth),
    .memRData(memRData), .memAddr(memAddr), .memWData(memWData),
    .lastByte(lastByte), .lastLine(lastLine), .pushRect(pushRect)
  );

  rect_ring #(.ENTRY_W(4*COORD_W), .DEPTH_LOG(RING_LOG)) uRing (
    .clk(clk), .rstN(rstN), .push(strb.push), .pushData(pushRect),
    .flushReq(flushReq), .invalidated(invalidated),
    .qValid(qValid), .qData(qData), .overflow(overflow)
  );

  assign memRe = strb.rdEn;
  assign memWe = strb.wrEn;
  assign {qX, qY, qW, qH} = qData;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRe && !memWe)); // R11
endmodule

// File: tb/tb_rect_engine.sv
`timescale 1ns/1ps
module tb_rect_engine;
  localparam int CW    = 12;
  localparam int AW    = 2 * CW + 3;
  localparam int SCR_W = 16;
  localparam int MEM_N = 1024;
  localparam int NVEC  = 9;

  typedef struct packed {
    logic [5:0]  depth;
    logic        copy;
    logic [31:0] colour;
    logic [CW-1:0] sx, sy, x, y, w, h;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{6'd24, 1'b0, 32'h00AABBCC, 12'd0, 12'd0, 12'd2, 12'd1, 12'd3,  12'd2},
    '{6'd8,  1'b0, 32'h0000005A, 12'd0, 12'd0, 12'd0, 12'd0, 12'd16, 12'd1},
    '{6'd16, 1'b0, 32'h00001234, 12'd0, 12'd0, 12'd5, 12'd3, 12'd4,  12'd3},
    '{6'd32, 1'b0, 32'hDEADBEEF, 12'd0, 12'd0, 12'd1, 12'd2, 12'd2,  12'd2},
    '{6'd24, 1'b1, 32'h0,        12'd0, 12'd0, 12'd2, 12'd0, 12'd3,  12'd2},
    '{6'd8,  1'b1, 32'h0,        12'd4, 12'd2, 12'd2, 12'd2, 12'd6,  12'd1},
    '{6'd16, 1'b1, 32'h0,        12'd1, 12'd1, 12'd2, 12'd3, 12'd4,  12'd4},
    '{6'd32, 1'b1, 32'h0,        12'd3, 12'd5, 12'd1, 12'd3, 12'd3,  12'd3},
    '{6'd12, 1'b0, 32'h00000F0E, 12'd0, 12'd0, 12'd0, 12'd8, 12'd5,  12'd1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, reqValid, reqCopy, flushReq, invalidated;
  logic [31:0] reqColour;
  logic [CW-1:0] reqSrcX, reqSrcY, reqX, reqY, reqW, reqH, scrWidth;
  logic [5:0] pixDepth;
  logic busy, done, memRe, memWe, qValid, overflow;
  logic [AW-1:0] memAddr;
  logic [7:0] memWData, memRData;
  logic [CW-1:0] qX, qY, qW, qH;

  rect_engine #(.COORD_W(CW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCopy(reqCopy), .reqColour(reqColour),
    .reqSrcX(reqSrcX), .reqSrcY(reqSrcY), .reqX(reqX), .reqY(reqY), .reqW(reqW), .reqH(reqH),
    .pixDepth(pixDepth), .scrWidth(scrWidth), .busy(busy), .done(done),
    .memRe(memRe), .memWe(memWe), .memAddr(memAddr), .memWData(memWData), .memRData(memRData),
    .flushReq(flushReq), .invalidated(invalidated), .qValid(qValid),
    .qX(qX), .qY(qY), .qW(qW), .qH(qH), .overflow(overflow)
  );

  logic [7:0] mem [MEM_N];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= 8'(i * 37 + 11);
    end else begin
      if (memWe) mem[memAddr[9:0]] <= memWData;
      if (memRe) memRData <= mem[memAddr[9:0]];
    end
  end

  int wrCnt, rdCnt;
  logic [AW-1:0] firstWr;
  always @(posedge clk) begin
    if (reqValid && !busy) begin
      wrCnt <= 0; rdCnt <= 0;
    end else begin
      if (memWe) begin
        if (wrCnt == 0) firstWr <= memAddr;
        wrCnt <= wrCnt + 1;
      end
      if (memRe) rdCnt <= rdCnt + 1;
    end
  end

  logic [4*CW-1:0] cap [600];
  int capN;
  always @(posedge clk) begin
    if (flushReq) capN <= 0;
    else if (qValid) begin
      if (capN < 600) cap[capN] <= {qX, qY, qW, qH};
      capN <= capN + 1;
    end
  end

  logic [7:0] refMem [MEM_N];
  logic [7:0] snap [MEM_N];
  int nChecks = 0, nErr = 0;
  bit timedOut = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic refInit();
    for (int i = 0; i < MEM_N; i++) refMem[i] = 8'(i * 37 + 11);
  endtask

  task automatic refApply(input vec_t v);
    int b = (int'(v.depth) + 7) / 8;
    for (int i = 0; i < MEM_N; i++) snap[i] = refMem[i];
    for (int l = 0; l < int'(v.h); l++)
      for (int k = 0; k < b * int'(v.w); k++) begin
        int d = b * (int'(v.x) + SCR_W * (int'(v.y) + l)) + k;
        int s = b * (int'(v.sx) + SCR_W * (int'(v.sy) + l)) + k;
        if (v.copy) refMem[d] = snap[s];
        else        refMem[d] = v.colour[8 * (k % b) +: 8];
      end
  endtask

  task automatic memDiffs(output int n);
    n = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== refMem[i]) n++;
  endtask

  task automatic doOp(input vec_t v);
    @(negedge clk);
    reqCopy = v.copy; reqColour = v.colour; pixDepth = v.depth;
    reqSrcX = v.sx; reqSrcY = v.sy; reqX = v.x; reqY = v.y; reqW = v.w; reqH = v.h;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7 done width", {done, busy}, 0);
  endtask

  task automatic doFlush(input bit inv, input int waitCyc);
    @(negedge clk);
    invalidated = inv; flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    repeat (waitCyc) @(negedge clk);
    invalidated = 1'b0;
  endtask

  task automatic runAll();
    vec_t v;
    int diffs;
    rstN = 1'b0; reqValid = 1'b0; reqCopy = 1'b0; flushReq = 1'b0; invalidated = 1'b0;
    reqColour = '0; reqSrcX = '0; reqSrcY = '0; reqX = '0; reqY = '0; reqW = '0; reqH = '0;
    pixDepth = 6'd8; scrWidth = CW'(SCR_W);
    repeat (3) @(negedge clk);
    check({busy, done, qValid, overflow, memRe, memWe} == 6'b0, "R11 in reset",
          {busy, done, qValid, overflow, memRe, memWe}, 0);
    rstN = 1'b1;
    refInit();
    @(negedge clk);
    check({busy, done, qValid, overflow, memRe, memWe} == 6'b0, "R11 after reset",
          {busy, done, qValid, overflow, memRe, memWe}, 0);

    for (int n = 0; n < NVEC; n++) begin
      int b, bpl;
      longint expFirst;
      v = VECS[n];
      b = (int'(v.depth) + 7) / 8;
      bpl = b * int'(v.w);
      doOp(v);
      refApply(v);
      memDiffs(diffs);
      check(diffs == 0, v.copy ? "R1 R3 copy result" : "R1 R2 fill result", diffs, 0);
      check(rdCnt == (v.copy ? bpl * int'(v.h) : 0), "R2 R3 read count", rdCnt,
            v.copy ? bpl * int'(v.h) : 0);
      expFirst = b * ((v.x) + SCR_W * ((v.copy && v.y > v.sy) ? v.y + v.h - 1 : v.y))
               + ((v.copy && v.x > v.sx) ? bpl - 1 : 0);
      check(firstWr == AW'(expFirst), "R4 R5 first write address", firstWr, expFirst);
      doFlush(1'b0, 6);
      check(capN == 1 && cap[0] == {v.x, v.y, v.w, v.h}, "R8 ring entry",
            cap[0], {v.x, v.y, v.w, v.h});
    end

    // R8: several entries drain in order
    doOp(VECS[0]); refApply(VECS[0]);
    doOp(VECS[5]); refApply(VECS[5]);
    doOp(VECS[2]); refApply(VECS[2]);
    doFlush(1'b0, 8);
    check(capN == 3, "R8 drain count", capN, 3);
    check(cap[0] == {VECS[0].x, VECS[0].y, VECS[0].w, VECS[0].h} &&
          cap[1] == {VECS[5].x, VECS[5].y, VECS[5].w, VECS[5].h} &&
          cap[2] == {VECS[2].x, VECS[2].y, VECS[2].w, VECS[2].h}, "R8 drain order", cap[1],
          {VECS[5].x, VECS[5].y, VECS[5].w, VECS[5].h});

    // R6: zero height fill and zero width copy
    v = '{6'd24, 1'b0, 32'h00112233, 12'd3, 12'd3, 12'd4, 12'd4, 12'd5, 12'd0};
    doOp(v);
    check(wrCnt == 0 && rdCnt == 0, "R6 zero h no access", wrCnt + rdCnt, 0);
    v = '{6'd8, 1'b1, 32'h0, 12'd0, 12'd0, 12'd7, 12'd9, 12'd0, 12'd3};
    doOp(v);
    check(wrCnt == 0 && rdCnt == 0, "R6 zero w no access", wrCnt + rdCnt, 0);
    doFlush(1'b0, 6);
    check(capN == 2 && cap[1] == {12'd7, 12'd9, 12'd0, 12'd3}, "R6 zero rect queued",
          cap[1], {12'd7, 12'd9, 12'd0, 12'd3});
    memDiffs(diffs);
    check(diffs == 0, "R6 memory untouched", diffs, 0);

    // R7: request while busy is ignored
    v = '{6'd8, 1'b0, 32'h000000C3, 12'd0, 12'd0, 12'd0, 12'd10, 12'd16, 12'd4};
    @(negedge clk);
    reqCopy = 1'b0; reqColour = v.colour; pixDepth = v.depth;
    reqX = v.x; reqY = v.y; reqW = v.w; reqH = v.h; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    reqColour = 32'h77; reqX = 12'd9; reqY = 12'd15; reqW = 12'd1; reqH = 12'd1; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
    refApply(v);
    memDiffs(diffs);
    check(diffs == 0, "R7 busy request no memory effect", diffs, 0);
    doFlush(1'b0, 6);
    check(capN == 1 && cap[0] == {v.x, v.y, v.w, v.h}, "R7 busy request not queued", capN, 1);

    // R9: invalidated flush discards
    doOp(VECS[1]); refApply(VECS[1]);
    doOp(VECS[3]); refApply(VECS[3]);
    doFlush(1'b1, 6);
    check(capN == 0, "R9 no output on discard", capN, 0);
    doFlush(1'b0, 6);
    check(capN == 0, "R9 ring empty after discard", capN, 0);

    // R10: overflow on 513 pushes
    check(overflow == 1'b0, "R10 no overflow yet", overflow, 0);
    for (int i = 0; i < 513; i++) begin
      v = '{6'd8, 1'b0, 32'h0, 12'd0, 12'd0, CW'(i), 12'd1, 12'd1, 12'd0};
      doOp(v);
    end
    check(overflow == 1'b1, "R10 overflow set", overflow, 1);
    doFlush(1'b0, 560);
    check(capN == 512, "R10 ring capacity", capN, 512);
    check(cap[0][4*CW-1 -: CW] == CW'(1), "R10 oldest overwritten", cap[0][4*CW-1 -: CW], 1);
    check(cap[511][4*CW-1 -: CW] == CW'(512), "R10 newest kept", cap[511][4*CW-1 -: CW], 512);
    check(overflow == 1'b1, "R10 overflow sticky", overflow, 1);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual=hung expected=complete");
    end
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule